// File: doc/BRIEF.md
# CAN Standard Frame Receiver

This block turns the sampled bit stream of a CAN bus into decoded standard frames. Each bus bit arrives on `rx_bit` together with a one-cycle `bit_stb`, issued once per bit time by the bit-timing logic. When the receiver is waiting for a frame, a dominant bit starts one. The receiver then removes stuff bits, collects the identifier, the remote-request flag, the control bits and up to eight data bytes, and checks the 15-bit CRC. It drives the acknowledge slot dominant for every frame whose CRC is correct. The acknowledge does not depend on the identifier, because acceptance filtering is done further downstream.

A completed frame appears on a valid/ready output. `frm_valid` rises one cycle after the strobe of the last end-of-frame bit. It stays high, and all frame fields stay stable, until `frm_ready` is seen high on a clock edge. The bus cannot be paused, so a frame that completes while the previous one is still unaccepted replaces it, and `frm_valid` stays high. Stuff, CRC and form errors are reported as single-cycle pulses, and the receiver then returns to waiting for a start bit. A separate level output reports a quiet bus after a long recessive run.

Top module: `can_rx`

## Requirements
- R1: While waiting for a frame, a strobe with `rx_bit`=0 starts a frame and recessive strobes are ignored.
- R2: After destuffing, the 18 header bits arrive in this order: identifier (11 bits, MSB first), RTR, IDE, r0 and DLC (4 bits, MSB first). They appear on `frm_id`, `frm_rtr`, `frm_ide`, `frm_r0` and `frm_dlc`.
- R3: The receiver collects min(DLC, 8) data bytes, and none when RTR=1. The first byte goes to `frm_data[7:0]` and the second to `frm_data[15:8]`. Each byte is received MSB first. Bytes that are not received read as zero.
- R4: From the start bit through the last CRC bit, the bit that follows five equal bits is a stuff bit and is removed. This also applies directly after the final CRC bit.
- R5: A sixth equal bit where a stuff bit is due gives a one-cycle `err_stuff`, a return to waiting, no acknowledge and no frame.
- R6: If the received CRC differs from the one computed over the start bit, header and data (polynomial 0x4599, initial value 0), a recessive CRC delimiter gives a one-cycle `err_crc` and no acknowledge.
- R7: For a correct frame, `ack_drive` is 1 from the cycle after the CRC delimiter strobe until the cycle after the acknowledge-slot strobe, whatever the identifier is.
- R8: A dominant CRC delimiter, acknowledge delimiter or any of the seven end-of-frame bits gives a one-cycle `err_form` and no frame.
- R9: `frm_valid` rises one cycle after the strobe of the seventh recessive end-of-frame bit.
- R10: `frm_valid` and the frame fields hold until an edge with `frm_ready`=1. A newer completed frame replaces an unaccepted one.
- R11: `bus_idle` goes to 1 on the edge that samples the 20th consecutive recessive strobe and goes to 0 on the edge that samples a dominant strobe. It is 0 after reset.
- R12: At most one of the error pulses is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_stb | input | 1 | One pulse per bus bit time |
| rx_bit | input | 1 | Sampled bus level, 0 = dominant |
| ack_drive | output | 1 | 1 = drive the bus dominant (acknowledge slot) |
| bus_idle | output | 1 | Long recessive run seen |
| frm_valid | output | 1 | Decoded frame available |
| frm_ready | input | 1 | Consumer accepts the frame |
| frm_id | output | 11 | Identifier |
| frm_rtr | output | 1 | Remote request flag |
| frm_ide | output | 1 | Identifier extension bit as received |
| frm_r0 | output | 1 | Reserved bit as received |
| frm_dlc | output | 4 | Data length code as received |
| frm_data | output | 64 | Data bytes, first byte in bits 7:0 |
| err_stuff | output | 1 | Stuff error pulse |
| err_crc | output | 1 | CRC error pulse |
| err_form | output | 1 | Form error pulse |

## Verification
If the stuff-run tracking drifts, field boundaries shift, and the identifier, data or CRC comes out wrong. This shows up as a spurious `err_stuff` or `err_crc` within the same frame, at the latest at the CRC delimiter. A wrong field counter moves the delimiter checks onto data bits, which gives `err_form` or a missing `ack_drive` well before the frame ends. An acknowledge that is mistimed is seen one bit time after the CRC delimiter. A wrong idle counter shows on `bus_idle` at the twentieth recessive strobe.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;
  typedef enum logic [2:0] {
    S_WAIT, S_HDR, S_DATA, S_CRC, S_CRCDEL, S_ACK, S_ACKDEL, S_EOF
  } rx_state_t;

  localparam int          CRC_W    = 15;
  localparam logic [14:0] CRC_POLY = 15'h4599;
endpackage

// File: rtl/can_rx_destuff.sv
module can_rx_destuff #(
  parameter int STUFF_RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic rx,
  input  logic start,
  input  logic en,
  output logic due,
  output logic pass,
  output logic err
);
  localparam int RW = $clog2(STUFF_RUN + 1);

  logic          last_q;
  logic [RW-1:0] run_q;

  assign due  = (run_q == RW'(STUFF_RUN));
  assign pass = stb && en && !due;
  assign err  = stb && en && due && (rx == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b1;
      run_q  <= '0;
    end else if (start) begin
      last_q <= rx;
      run_q  <= RW'(1);
    end else if (stb && en) begin
      if (rx != last_q) begin
        last_q <= rx;
        run_q  <= RW'(1);
      end else if (!due) begin
        run_q <= run_q + RW'(1);
      end
    end
  end

  assert_run_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RW'(STUFF_RUN));
  assert_stuff_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && en && due && !err) |=> (run_q == RW'(1)));
endmodule

// File: rtl/can_rx_crc15.sv
module can_rx_crc15
  import can_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             shift,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);
  logic fb;
  assign fb = din ^ crc[CRC_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc <= '0;
    else if (clear)  crc <= '0;
    else if (shift)  crc <= {crc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  end
endmodule

// File: rtl/can_rx_idle.sv
module can_rx_idle #(
  parameter int IDLE_RUN = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic rx,
  output logic idle
);
  localparam int IW = $clog2(IDLE_RUN + 1);
  logic [IW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (stb) begin
      if (!rx)                          cnt_q <= '0;
      else if (cnt_q != IW'(IDLE_RUN))  cnt_q <= cnt_q + IW'(1);
    end
  end

  assign idle = (cnt_q == IW'(IDLE_RUN));

  assert_idle_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle) |-> $past(stb && !rx));
  assert_idle_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle) |-> $past(stb && rx));
endmodule

// File: rtl/can_rx.sv
module can_rx
  import can_rx_pkg::*;
#(
  parameter int ID_W      = 11,
  parameter int MAX_BYTES = 8,
  parameter int STUFF_RUN = 5,
  parameter int EOF_BITS  = 7,
  parameter int IDLE_RUN  = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bit_stb,
  input  logic                   rx_bit,
  output logic                   ack_drive,
  output logic                   bus_idle,
  output logic                   frm_valid,
  input  logic                   frm_ready,
  output logic [ID_W-1:0]        frm_id,
  output logic                   frm_rtr,
  output logic                   frm_ide,
  output logic                   frm_r0,
  output logic [3:0]             frm_dlc,
  output logic [MAX_BYTES*8-1:0] frm_data,
  output logic                   err_stuff,
  output logic                   err_crc,
  output logic                   err_form
);
  localparam int HDR_BITS = ID_W + 7;
  localparam int DATA_W   = MAX_BYTES * 8;
  localparam int CNT_W    = $clog2(DATA_W + 1);
  localparam int IDX_W    = $clog2(DATA_W);

  rx_state_t         st_q;
  logic [CNT_W-1:0]  cnt_q, data_bits_q;
  logic [HDR_BITS-1:0] hdr_q, hdr_nx;
  logic [DATA_W-1:0] data_q;
  logic [CRC_W-1:0]  rxcrc_q, crc_calc;
  logic [3:0]        nb_c;
  logic [IDX_W-1:0]  didx;
  logic start, in_stuff, due, dbit, pbit, stuff_err, frame_done;

  assign start    = (st_q == S_WAIT) && bit_stb && !rx_bit;
  assign in_stuff = (st_q == S_HDR) || (st_q == S_DATA) || (st_q == S_CRC) ||
                    ((st_q == S_CRCDEL) && due);
  assign pbit     = bit_stb && !in_stuff;
  assign hdr_nx   = {hdr_q[HDR_BITS-2:0], rx_bit};
  assign didx     = IDX_W'(cnt_q) ^ IDX_W'(7);

  always_comb begin
    if (hdr_nx[6])                         nb_c = 4'd0;
    else if (hdr_nx[3:0] > 4'(MAX_BYTES))  nb_c = 4'(MAX_BYTES);
    else                                   nb_c = hdr_nx[3:0];
  end

  can_rx_destuff #(.STUFF_RUN(STUFF_RUN)) u_destuff (
    .clk(clk), .rst_n(rst_n), .stb(bit_stb), .rx(rx_bit), .start(start),
    .en(in_stuff), .due(due), .pass(dbit), .err(stuff_err)
  );

  can_rx_crc15 u_crc (
    .clk(clk), .rst_n(rst_n), .clear(start),
    .shift(dbit && ((st_q == S_HDR) || (st_q == S_DATA))),
    .din(rx_bit), .crc(crc_calc)
  );

  can_rx_idle #(.IDLE_RUN(IDLE_RUN)) u_idle (
    .clk(clk), .rst_n(rst_n), .stb(bit_stb), .rx(rx_bit), .idle(bus_idle)
  );

  assign ack_drive = (st_q == S_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_WAIT; cnt_q <= '0; data_bits_q <= '0;
      hdr_q <= '0; data_q <= '0; rxcrc_q <= '0;
      err_stuff <= 1'b0; err_crc <= 1'b0; err_form <= 1'b0; frame_done <= 1'b0;
    end else begin
      err_stuff <= 1'b0; err_crc <= 1'b0; err_form <= 1'b0; frame_done <= 1'b0;
      if (stuff_err) begin
        err_stuff <= 1'b1;
        st_q      <= S_WAIT;
      end else begin
        case (st_q)
          S_WAIT: if (start) begin
            st_q <= S_HDR; cnt_q <= '0; hdr_q <= '0; data_q <= '0;
          end
          S_HDR: if (dbit) begin
            hdr_q <= hdr_nx;
            if (cnt_q == CNT_W'(HDR_BITS - 1)) begin
              cnt_q       <= '0;
              data_bits_q <= CNT_W'({nb_c, 3'b000});
              st_q        <= (nb_c == 4'd0) ? S_CRC : S_DATA;
            end else cnt_q <= cnt_q + CNT_W'(1);
          end
          S_DATA: if (dbit) begin
            data_q[didx] <= rx_bit;
            if (cnt_q == data_bits_q - CNT_W'(1)) begin
              cnt_q <= '0; st_q <= S_CRC;
            end else cnt_q <= cnt_q + CNT_W'(1);
          end
          S_CRC: if (dbit) begin
            rxcrc_q <= {rxcrc_q[CRC_W-2:0], rx_bit};
            if (cnt_q == CNT_W'(CRC_W - 1)) begin
              cnt_q <= '0; st_q <= S_CRCDEL;
            end else cnt_q <= cnt_q + CNT_W'(1);
          end
          S_CRCDEL: if (pbit) begin
            if (!rx_bit)                     begin err_form <= 1'b1; st_q <= S_WAIT; end
            else if (rxcrc_q != crc_calc)    begin err_crc  <= 1'b1; st_q <= S_WAIT; end
            else                             st_q <= S_ACK;
          end
          S_ACK: if (pbit) st_q <= S_ACKDEL;
          S_ACKDEL: if (pbit) begin
            if (!rx_bit) begin err_form <= 1'b1; st_q <= S_WAIT; end
            else begin cnt_q <= '0; st_q <= S_EOF; end
          end
          S_EOF: if (pbit) begin
            if (!rx_bit) begin err_form <= 1'b1; st_q <= S_WAIT; end
            else if (cnt_q == CNT_W'(EOF_BITS - 1)) begin
              frame_done <= 1'b1; st_q <= S_WAIT;
            end else cnt_q <= cnt_q + CNT_W'(1);
          end
          default: st_q <= S_WAIT;
        endcase
      end
    end
  end

  // Output holding register: a finished frame loads it, a handshake empties it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_valid <= 1'b0; frm_id <= '0; frm_rtr <= 1'b0; frm_ide <= 1'b0;
      frm_r0 <= 1'b0; frm_dlc <= '0; frm_data <= '0;
    end else if (frame_done) begin
      frm_valid <= 1'b1;
      frm_id    <= hdr_q[HDR_BITS-1:7];
      frm_rtr   <= hdr_q[6];
      frm_ide   <= hdr_q[5];
      frm_r0    <= hdr_q[4];
      frm_dlc   <= hdr_q[3:0];
      frm_data  <= data_q;
    end else if (frm_ready) begin
      frm_valid <= 1'b0;
    end
  end

  assert_ack_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_drive && !bit_stb) |=> ack_drive);
  assert_ack_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_drive && bit_stb) |=> !ack_drive);
  assert_ack_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_drive) |-> $past(bit_stb && rx_bit));
  assert_no_ack_on_crc_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_crc |-> !ack_drive);
  assert_valid_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_ready) |=> frm_valid);
  assert_valid_after_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frm_valid) |-> $past(bit_stb && rx_bit, 2));
  assert_one_error_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({err_stuff, err_crc, err_form}) <= 1);
  assert_form_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_form |=> !err_form);
endmodule

// File: tb/tb_can_rx.sv
module tb_can_rx;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, bit_stb, rx_bit, frm_ready;
  logic ack_drive, bus_idle, frm_valid, frm_rtr, frm_ide, frm_r0;
  logic err_stuff, err_crc, err_form;
  logic [10:0] frm_id;
  logic [3:0]  frm_dlc;
  logic [63:0] frm_data;

  can_rx dut (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .rx_bit(rx_bit),
    .ack_drive(ack_drive), .bus_idle(bus_idle), .frm_valid(frm_valid),
    .frm_ready(frm_ready), .frm_id(frm_id), .frm_rtr(frm_rtr), .frm_ide(frm_ide),
    .frm_r0(frm_r0), .frm_dlc(frm_dlc), .frm_data(frm_data),
    .err_stuff(err_stuff), .err_crc(err_crc), .err_form(err_form)
  );

  typedef struct {
    int          kind;   // 0 frame, 1 stuff, 2 crc, 3 form
    logic [10:0] id;
    logic        rtr;
    logic [3:0]  dlc;
    logic [63:0] data;
  } exp_t;

  exp_t expq[$];
  int   checks = 0;
  int   fails  = 0;
  bit   finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); rx_bit = b; bit_stb = 1'b1;
    @(negedge clk); bit_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [10:0] id, input logic rtr, input logic [3:0] dlc,
                            input logic [63:0] data, input int crc_flip, input int dom_pos,
                            input bit push);
    logic raw[$];
    logic wire_q[$];
    logic tail[10];
    logic [14:0] c;
    logic [63:0] dexp;
    logic last;
    int nb, run;
    exp_t e;
    bit exp_ack;
    raw.push_back(1'b0);
    for (int i = 10; i >= 0; i--) raw.push_back(id[i]);
    raw.push_back(rtr); raw.push_back(1'b0); raw.push_back(1'b0);
    for (int i = 3; i >= 0; i--) raw.push_back(dlc[i]);
    nb = rtr ? 0 : ((dlc > 8) ? 8 : int'(dlc));
    dexp = '0;
    for (int by = 0; by < nb; by++)
      for (int bi = 7; bi >= 0; bi--) begin
        raw.push_back(data[by*8+bi]);
        dexp[by*8+bi] = data[by*8+bi];
      end
    c = '0;
    for (int i = 0; i < raw.size(); i++) begin
      logic fb;
      fb = raw[i] ^ c[14];
      c = {c[13:0], 1'b0};
      if (fb) c = c ^ 15'h4599;
    end
    if (crc_flip >= 0) c[crc_flip] = ~c[crc_flip];
    for (int i = 14; i >= 0; i--) raw.push_back(c[i]);
    run = 0; last = 1'b1;
    for (int i = 0; i < raw.size(); i++) begin
      wire_q.push_back(raw[i]);
      if (i == 0 || raw[i] != last) run = 1; else run++;
      last = raw[i];
      if (run == 5) begin
        wire_q.push_back(~last);
        last = ~last; run = 1;
      end
    end
    for (int i = 0; i < 10; i++) tail[i] = 1'b1;
    if (dom_pos >= 0) tail[dom_pos] = 1'b0;
    e.id = id; e.rtr = rtr; e.dlc = dlc; e.data = dexp;
    if (dom_pos == 0)                  e.kind = 3;
    else if (crc_flip >= 0)            e.kind = 2;
    else if (dom_pos >= 2)             e.kind = 3;
    else                               e.kind = 0;
    exp_ack = (dom_pos != 0) && (crc_flip < 0);
    if (push) expq.push_back(e);
    for (int i = 0; i < wire_q.size(); i++) send_bit(wire_q[i]);
    send_bit(tail[0]);
    chk(ack_drive == exp_ack, "R7", "ack in slot", 64'(ack_drive), 64'(exp_ack));
    send_bit(tail[1]);
    chk(ack_drive == 1'b0, "R7", "ack released", 64'(ack_drive), 64'd0);
    for (int i = 2; i < 10; i++) send_bit(tail[i]);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
  endtask

  task automatic pop_cmp(input int kind);
    exp_t e;
    if (expq.size() == 0) begin
      chk(1'b0, "R12", "unexpected event kind", 64'(kind), 64'hFFFF);
      return;
    end
    e = expq.pop_front();
    chk(e.kind == kind, "R5/R6/R8/R9", "event kind", 64'(kind), 64'(e.kind));
    if (kind == 0 && e.kind == 0) begin
      chk(frm_id == e.id, "R2", "id", 64'(frm_id), 64'(e.id));
      chk(frm_rtr == e.rtr && frm_dlc == e.dlc && !frm_ide && !frm_r0, "R2",
          "rtr/dlc/ide/r0", {57'd0, frm_rtr, frm_ide, frm_r0, frm_dlc},
          {57'd0, e.rtr, 2'b00, e.dlc});
      chk(frm_data == e.data, "R3", "data", frm_data, e.data);
    end
  endtask

  // Monitor: pops expected items as results appear at the ports.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if ($countones({err_stuff, err_crc, err_form}) > 1)
        chk(1'b0, "R12", "several error pulses", 64'({err_stuff, err_crc, err_form}), 64'd0);
      if (frm_valid && frm_ready) pop_cmp(0);
      if (err_stuff) pop_cmp(1);
      if (err_crc)   pop_cmp(2);
      if (err_form)  pop_cmp(3);
    end
  end

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", 64'd0, 64'd1);
    summary();
  end

  initial begin
    rst_n = 1'b0; bit_stb = 1'b0; rx_bit = 1'b1; frm_ready = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(!frm_valid && !ack_drive && !bus_idle && !err_stuff && !err_crc && !err_form,
        "R11", "reset state", {58'd0, frm_valid, ack_drive, bus_idle, err_stuff, err_crc, err_form}, 64'd0);

    // R1 / R11: recessive bits while waiting do nothing but feed the idle counter
    repeat (19) send_bit(1'b1);
    chk(bus_idle == 1'b0, "R11", "idle after 19", 64'(bus_idle), 64'd0);
    send_bit(1'b1);
    chk(bus_idle == 1'b1, "R11", "idle after 20", 64'(bus_idle), 64'd1);
    chk(!frm_valid, "R1", "no frame from recessive bits", 64'(frm_valid), 64'd0);

    send_frame(11'h123, 1'b0, 4'd2, 64'h0000_0000_0000_EFBE, -1, -1, 1'b1);   // R2 R9
    chk(bus_idle == 1'b0, "R11", "idle cleared by frame", 64'(bus_idle), 64'd0);
    send_frame(11'h000, 1'b0, 4'd8, 64'h0, -1, -1, 1'b1);                     // R4 zeros
    send_frame(11'h7FF, 1'b0, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, -1, -1, 1'b1);   // R4 ones
    send_frame(11'h555, 1'b1, 4'd4, 64'h1122_3344_5566_7788, -1, -1, 1'b1);   // R3 remote
    send_frame(11'h2A1, 1'b0, 4'd12, 64'h0123_4567_89AB_CDEF, -1, -1, 1'b1);  // R3 dlc>8
    send_frame(11'h0F0, 1'b0, 4'd0, 64'h0, -1, 1, 1'b1);                      // R3 empty, R7
    send_frame(11'h3C3, 1'b0, 4'd3, 64'h0000_0000_00A5_5A0F, 3, -1, 1'b1);   // R6
    send_frame(11'h111, 1'b0, 4'd1, 64'h42, -1, 0, 1'b1);                     // R8 crc delim
    send_frame(11'h222, 1'b0, 4'd1, 64'h43, -1, 2, 1'b1);                     // R8 ack delim
    send_frame(11'h333, 1'b0, 4'd1, 64'h44, -1, 5, 1'b1);                     // R8 eof
    send_frame(11'h444, 1'b0, 4'd1, 64'h45, -1, 9, 1'b1);                     // R8 last eof

    // R5: six dominant bits in a row
    begin
      exp_t e;
      e.kind = 1; e.id = '0; e.rtr = 1'b0; e.dlc = '0; e.data = '0;
      expq.push_back(e);
    end
    repeat (6) send_bit(1'b0);
    chk(ack_drive == 1'b0, "R5", "no ack after stuff error", 64'(ack_drive), 64'd0);
    repeat (12) send_bit(1'b1);

    // R10: hold, then replacement by a newer frame
    @(posedge clk); #1 frm_ready = 1'b0;
    send_frame(11'h1AB, 1'b0, 4'd1, 64'h77, -1, -1, 1'b0);
    repeat (4) @(negedge clk);
    chk(frm_valid && frm_id == 11'h1AB, "R10", "held frame", {52'd0, frm_valid, frm_id}, {52'd1, 11'h1AB});
    send_frame(11'h2CD, 1'b0, 4'd2, 64'h9988, -1, -1, 1'b1);
    chk(frm_valid && frm_id == 11'h2CD, "R10", "replaced frame", {52'd0, frm_valid, frm_id}, {52'd1, 11'h2CD});
    @(posedge clk); #1 frm_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(!frm_valid, "R10", "valid dropped after accept", 64'(frm_valid), 64'd0);

    repeat (10) @(negedge clk);
    chk(expq.size() == 0, "R9", "all expected events seen", 64'(expq.size()), 64'd0);
    summary();
  end
endmodule